// File: doc/BRIEF.md
# Video DRAM Address Multiplexer with Column Increment

This block drives the shared, multiplexed address bus of a video DRAM array. It holds a row address, a column address and a bank select. An access request captures them. During the row-strobe phase it puts the row on the bus, and during the column-strobe phase it puts the column there. An external strobe sequencer supplies the phase and refresh-active inputs. The block has no strobe timing of its own.

A single column-increment input has two jobs. During a normal access it advances the held column by one on each clock, for burst-style transfers. While a refresh is running it instead keeps the refresh cycle open, for as many clocks as it stays high. During refresh the bus carries an internal refresh row counter. The counter steps by one each time a refresh cycle completes.

A configuration register loads from the row, column and bank inputs while an active-low load strobe is low. Its bit 0 chooses flow-through operation, in which the bus follows the inputs directly and no latching takes place.

Top module: `vram_addr_mux`

## Requirements
- R1: After reset, the following all read zero: the held row, the held column, the held bank, the refresh row counter, the configuration register and the refresh-done pulse. With refresh inactive and the phase low, addr_out therefore reads 0.
- R2: With refresh inactive, flow-through off and col_phase = 0, addr_out equals the held row.
- R3: With refresh inactive, flow-through off and col_phase = 1, addr_out equals the held column, and bank_out equals the held bank.
- R4: Row, column and bank are captured only at the clock edge where acc_req is high and was low at the previous edge. Input changes while acc_req stays high do not affect addr_out.
- R5: With refresh inactive and flow-through off, every clock edge at which col_inc is high adds one to the held column, wrapping from 2047 to 0. A capture edge takes priority over the increment.
- R6: While rfsh_act is high, addr_out equals rfsh_row, regardless of col_phase and flow-through.
- R7: A refresh cycle starts at a rising edge of rfsh_act. rfsh_done pulses after RFSH_LEN further clock edges, plus one more edge for each of those edges at which col_inc is high. col_inc does not change the held column during refresh.
- R8: rfsh_done is a one-cycle pulse. rfsh_row increases by one, modulo 2048, in exactly the cycle in which rfsh_done is high, and is otherwise stable.
- R9: At each clock edge with mode_ld_n low, cfg_out loads {bank_in[1:0], col_in[9:0], row_in[9:0]}. The most significant row bit and the most significant column bit are dropped. With mode_ld_n high, cfg_out holds.
- R10: When cfg_out[0] = 1 (flow-through), addr_out shows row_in or col_in according to col_phase, bank_out shows bank_in, and col_inc has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_in | input | 11 | Row address input, also configuration data |
| col_in | input | 11 | Column address input, also configuration data |
| bank_in | input | 2 | Bank select input, also configuration data |
| acc_req | input | 1 | Access request; rising edge captures addresses |
| col_phase | input | 1 | 0 = row phase, 1 = column phase |
| rfsh_act | input | 1 | Refresh in progress; overrides the phase selection |
| col_inc | input | 1 | Column increment, or refresh extension during refresh |
| mode_ld_n | input | 1 | Active-low configuration load |
| addr_out | output | 11 | Multiplexed DRAM address bus |
| bank_out | output | 2 | Selected bank |
| rfsh_row | output | 11 | Refresh row counter |
| rfsh_done | output | 1 | One-cycle pulse at the end of a refresh cycle |
| cfg_out | output | 22 | Configuration register contents |

## Verification
The assertions assume that rfsh_act is held high until rfsh_done has pulsed, and that a new refresh begins only from a low level of rfsh_act. They also assume that mode_ld_n is pulsed only while no access or refresh is in progress. The stimulus respects all three assumptions. It raises rfsh_act once per refresh, waits for the done pulse and lowers rfsh_act afterwards, and it loads the configuration only while acc_req and rfsh_act are low. A low cycle of acc_req always precedes each new capture, so the rising-edge detection is exercised deliberately.

// File: rtl/vram_mux_pkg.sv
package vram_mux_pkg;
    localparam int VRA_ADDR_W   = 11;
    localparam int VRA_BANK_W   = 2;
    localparam int VRA_RFSH_LEN = 4;

    function automatic int cfg_width(input int addr_w, input int bank_w);
        return 2 * (addr_w - 1) + bank_w;
    endfunction
endpackage

// File: rtl/vram_prog_reg.sv
module vram_prog_reg #(
    parameter int ADDR_W = vram_mux_pkg::VRA_ADDR_W,
    parameter int BANK_W = vram_mux_pkg::VRA_BANK_W,
    localparam int CFG_W = vram_mux_pkg::cfg_width(ADDR_W, BANK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld_n,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [ADDR_W-1:0] col_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [CFG_W-1:0]  cfg_q
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } prog_st_t;

    prog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mode_ld_n) begin
            st_d.cfg = {bank_in, col_in[ADDR_W-2:0], row_in[ADDR_W-2:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ld_n |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/vram_addr_latch.sv
module vram_addr_latch #(
    parameter int ADDR_W = vram_mux_pkg::VRA_ADDR_W,
    parameter int BANK_W = vram_mux_pkg::VRA_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              inc_en,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [ADDR_W-1:0] col_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_q,
    output logic [BANK_W-1:0] bank_q
);
    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [BANK_W-1:0] bank;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic    capture;

    always_comb begin
        st_d     = st_q;
        st_d.req = acc_req;
        capture  = acc_req && !st_q.req;
        if (capture) begin
            st_d.row  = row_in;
            st_d.col  = col_in;
            st_d.bank = bank_in;
        end else if (inc_en) begin
            st_d.col = st_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_q  = st_q.row;
    assign col_q  = st_q.col;
    assign bank_q = st_q.bank;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !st_q.req) |=> ($stable(row_q) && $stable(bank_q))); // R4
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !(acc_req && !st_q.req)) |=> col_q == ADDR_W'($past(col_q) + 1'b1)); // R5
    AST_COL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !(acc_req && !st_q.req)) |=> $stable(col_q)); // R7
endmodule

// File: rtl/vram_rfsh_ctl.sv
module vram_rfsh_ctl #(
    parameter int ADDR_W   = vram_mux_pkg::VRA_ADDR_W,
    parameter int RFSH_LEN = vram_mux_pkg::VRA_RFSH_LEN,
    localparam int TMR_W   = (RFSH_LEN > 2) ? $clog2(RFSH_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfsh_act,
    input  logic              hold,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic              rfsh_done
);
    typedef struct packed {
        logic              act;
        logic              busy;
        logic [TMR_W-1:0]  tmr;
        logic              done;
        logic [ADDR_W-1:0] row;
    } rf_st_t;

    rf_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.act  = rfsh_act;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (rfsh_act && !st_q.act) begin
                st_d.busy = 1'b1;
                st_d.tmr  = TMR_W'(RFSH_LEN - 1);
            end
        end else if (!hold) begin
            if (st_q.tmr == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.row  = st_q.row + 1'b1;
            end else begin
                st_d.tmr = st_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rfsh_row  = st_q.row;
    assign rfsh_done = st_q.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_done |=> !rfsh_done); // R8
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_done |-> rfsh_row == ADDR_W'($past(rfsh_row) + 1'b1)); // R8
    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_done |-> $stable(rfsh_row)); // R8
    AST_HOLD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && hold) |=> !rfsh_done); // R7
endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux #(
    parameter int ADDR_W   = vram_mux_pkg::VRA_ADDR_W,
    parameter int BANK_W   = vram_mux_pkg::VRA_BANK_W,
    parameter int RFSH_LEN = vram_mux_pkg::VRA_RFSH_LEN,
    localparam int CFG_W   = vram_mux_pkg::cfg_width(ADDR_W, BANK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [ADDR_W-1:0] col_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic              acc_req,
    input  logic              col_phase,
    input  logic              rfsh_act,
    input  logic              col_inc,
    input  logic              mode_ld_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BANK_W-1:0] bank_out,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic              rfsh_done,
    output logic [CFG_W-1:0]  cfg_out
);
    logic              flow;
    logic              inc_en;
    logic [ADDR_W-1:0] row_lat, col_lat;
    logic [BANK_W-1:0] bank_lat;
    logic [ADDR_W-1:0] row_src, col_src;

    vram_prog_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .mode_ld_n(mode_ld_n),
        .row_in(row_in), .col_in(col_in), .bank_in(bank_in), .cfg_q(cfg_out)
    );

    assign flow   = cfg_out[0];
    assign inc_en = col_inc && !rfsh_act && !flow;

    vram_addr_latch #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .inc_en(inc_en),
        .row_in(row_in), .col_in(col_in), .bank_in(bank_in),
        .row_q(row_lat), .col_q(col_lat), .bank_q(bank_lat)
    );

    vram_rfsh_ctl #(.ADDR_W(ADDR_W), .RFSH_LEN(RFSH_LEN)) u_rfsh (
        .clk(clk), .rst_n(rst_n), .rfsh_act(rfsh_act), .hold(col_inc),
        .rfsh_row(rfsh_row), .rfsh_done(rfsh_done)
    );

    always_comb begin
        row_src  = flow ? row_in  : row_lat;
        col_src  = flow ? col_in  : col_lat;
        bank_out = flow ? bank_in : bank_lat;
        if (rfsh_act)       addr_out = rfsh_row;
        else if (col_phase) addr_out = col_src;
        else                addr_out = row_src;
    end

    AST_RFSH_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_act |-> addr_out == rfsh_row); // R6
    AST_ROW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_act && !col_phase && !cfg_out[0]) |-> addr_out == row_lat); // R2
    AST_COL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_act && col_phase && !cfg_out[0]) |-> addr_out == col_lat); // R3
    AST_FLOW_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_act && cfg_out[0]) |-> addr_out == (col_phase ? col_in : row_in)); // R10
endmodule

// File: tb/vram_addr_mux_tb.sv
`timescale 1ns/1ps
module vram_addr_mux_tb;
    localparam int AW = 11;
    localparam int BW = 2;
    localparam int RL = 4;
    localparam int CW = 2 * (AW - 1) + BW;
    localparam int NV = 4;

    // vector: {row, col, bank}; expected row phase = row, column phase = col
    localparam logic [2*AW+BW-1:0] VEC [NV] = '{
        {11'h000, 11'h7FF, 2'd1},
        {11'h5A5, 11'h2AA, 2'd2},
        {11'h7FF, 11'h001, 2'd3},
        {11'h123, 11'h456, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] row_in = '0, col_in = '0;
    logic [BW-1:0] bank_in = '0;
    logic          acc_req = 1'b0, col_phase = 1'b0, rfsh_act = 1'b0;
    logic          col_inc = 1'b0, mode_ld_n = 1'b1;
    logic [AW-1:0] addr_out, rfsh_row;
    logic [BW-1:0] bank_out;
    logic          rfsh_done;
    logic [CW-1:0] cfg_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vram_addr_mux #(.ADDR_W(AW), .BANK_W(BW), .RFSH_LEN(RL)) u_dut (
        .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_in(col_in),
        .bank_in(bank_in), .acc_req(acc_req), .col_phase(col_phase),
        .rfsh_act(rfsh_act), .col_inc(col_inc), .mode_ld_n(mode_ld_n),
        .addr_out(addr_out), .bank_out(bank_out), .rfsh_row(rfsh_row),
        .rfsh_done(rfsh_done), .cfg_out(cfg_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 addr_out", 32'(addr_out), 32'h0);
        chk("R1 rfsh_row", 32'(rfsh_row), 32'h0);
        chk("R1 cfg_out", 32'(cfg_out), 32'h0);
        chk("R1 rfsh_done", 32'(rfsh_done), 32'h0);
        chk("R1 bank_out", 32'(bank_out), 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {row_in, col_in, bank_in} = VEC[i];
            acc_req = 1'b1; col_phase = 1'b0;
            @(negedge clk);
            row_in = ~row_in; col_in = ~col_in;
            #1 chk("R2 row phase", 32'(addr_out), 32'(VEC[i][2*AW+BW-1 -: AW]));
            col_phase = 1'b1;
            #1 chk("R3 col phase", 32'(addr_out), 32'(VEC[i][AW+BW-1 -: AW]));
            chk("R3 bank_out", 32'(bank_out), 32'(VEC[i][BW-1:0]));
            acc_req = 1'b0;
        end

        // R4: held request does not recapture
        @(negedge clk); row_in = 11'h111; acc_req = 1'b1; col_phase = 1'b0;
        @(negedge clk); row_in = 11'h222;
        @(negedge clk); #1 chk("R4 no recapture", 32'(addr_out), 32'h111);
        acc_req = 1'b0;

        // R5: increment and wrap
        @(negedge clk); col_in = 11'h7FE; acc_req = 1'b1;
        @(negedge clk); col_inc = 1'b1; col_phase = 1'b1;
        #1 chk("R5 start", 32'(addr_out), 32'h7FE);
        @(negedge clk); #1 chk("R5 step", 32'(addr_out), 32'h7FF);
        @(negedge clk); col_inc = 1'b0;
        #1 chk("R5 wrap", 32'(addr_out), 32'h000);
        acc_req = 1'b0;

        // R6 R7 R8: refresh with two extension edges
        @(negedge clk); rfsh_act = 1'b1; col_inc = 1'b1;
        #1 chk("R6 refresh addr", 32'(addr_out), 32'h0);
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk); col_inc = 1'b0;
        chk("R7 no early done", 32'(rfsh_done), 32'h0);
        cnt = 2;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (rfsh_done) break;
        end
        chk("R7 extended length", 32'(cnt), 32'(RL + 2));
        #1 chk("R8 row advanced", 32'(rfsh_row), 32'h1);
        chk("R6 refresh addr follows", 32'(addr_out), 32'h1);
        @(negedge clk); chk("R8 single pulse", 32'(rfsh_done), 32'h0);
        rfsh_act = 1'b0;
        #1 chk("R7 column untouched", 32'(addr_out), 32'h000);

        // R7 R8: refresh without extension
        @(negedge clk); rfsh_act = 1'b1;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (rfsh_done) break;
        end
        chk("R7 base length", 32'(cnt), 32'(RL + 1));
        chk("R8 second step", 32'(rfsh_row), 32'h2);
        rfsh_act = 1'b0;

        // R9: configuration load drops MSBs
        @(negedge clk); mode_ld_n = 1'b0; row_in = 11'h7FE; col_in = 11'h5AB; bank_in = 2'd3;
        @(negedge clk); mode_ld_n = 1'b1; row_in = 11'h000; col_in = 11'h000; bank_in = 2'd0;
        chk("R9 cfg load", 32'(cfg_out), 32'({2'd3, 10'h1AB, 10'h3FE}));
        @(negedge clk); chk("R9 cfg hold", 32'(cfg_out), 32'({2'd3, 10'h1AB, 10'h3FE}));

        // R10: flow-through
        @(negedge clk); mode_ld_n = 1'b0; row_in = 11'h001; col_in = 11'h000; bank_in = 2'd0;
        @(negedge clk); mode_ld_n = 1'b1;
        row_in = 11'h3C3; col_in = 11'h155; bank_in = 2'd2; col_phase = 1'b0;
        #1 chk("R10 flow row", 32'(addr_out), 32'h3C3);
        chk("R10 flow bank", 32'(bank_out), 32'h2);
        col_phase = 1'b1; col_inc = 1'b1;
        #1 chk("R10 flow col", 32'(addr_out), 32'h155);
        @(negedge clk); @(negedge clk); col_inc = 1'b0;
        #1 chk("R10 inc ignored", 32'(addr_out), 32'h155);
        @(negedge clk); mode_ld_n = 1'b0; row_in = 11'h000;
        @(negedge clk); mode_ld_n = 1'b1;
        #1 chk("R10 latch again", 32'(addr_out), 32'h000);

        finish_run();
    end
endmodule